// File: doc/BRIEF.md
# Cascadable CAM Host Bus Cycle and Match Chain Interface

This block is the host-side front end of a content-addressable memory device that can be cascaded with others of its kind. The host runs strobed bus cycles with an active-low chip enable. The block sees the chip enable, the write select, the command/data select and the chain-enable request only through two-flop synchronizers on a free-running system clock. At the falling strobe edge it latches the cycle controls. While a read cycle is open it drives the 16-bit data bus. At the rising strobe edge it closes the cycle, sends one clock pulse to the segment counters, hands any write data to the core and commits the chain state.

When the chain is committed as enabled, the active-low match flag is formed from this device's own match and the upstream match input. Devices are wired in priority order, so the flag of the last device is the match flag for the whole system. The block also reports when this device holds the highest-priority match in the chain. The match array, the command engine and the counters sit outside the block and appear here as plain ports.

Top module: `camChainBus`

## Requirements
- R1: While reset is asserted and just after it, matchFlagN is 1, and dataOe, segClk, wrStrobe, selected and cycleActive are all 0.
- R2: wrN, cmdN and ecN are sampled only at the falling strobe edge. Changing them while the strobe is low does not alter cycleKind, dataOe or the chain state that the cycle commits.
- R3: cycleKind equals {latched wrN, latched cmdN}: 2'b00 is a command write, 2'b01 a data write, 2'b10 a command read and 2'b11 a data read. cycleActive is 1 from the falling strobe edge until the rising one.
- R4: dataOe is 1 only while a cycle is active and its latched wrN is 1. While dataOe is 1, dataOut carries readData. With the strobe high the bus is never driven.
- R5: Every rising strobe edge produces exactly one single-cycle segClk pulse. A strobe transition shows in the registered outputs at the third rising clock edge at which the new enN level is present.
- R6: At the rising strobe edge of a write cycle (latched wrN 0), wrStrobe pulses for one cycle and wrData captures dataIn. Read cycles leave wrData unchanged.
- R7: The chain is enabled at a rising strobe edge exactly when ecN was latched as 0 at that cycle's falling edge. While the chain is disabled, matchFlagN is 1.
- R8: With the chain enabled and flagEnable 1, matchFlagN is 0 when localMatch is 1 or matchInN is 0, and 1 otherwise.
- R9: With the chain enabled and flagEnable 0, matchFlagN equals matchInN.
- R10: A cfgChange pulse disables the chain on the next clock edge, which forces matchFlagN to 1. It takes priority over a commit at that edge.
- R11: selected is 1 exactly when the chain is enabled, flagEnable and localMatch are 1, and matchInN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enN | input | 1 | Active-low bus strobe (chip enable), asynchronous |
| wrN | input | 1 | Write select, 0 = write, 1 = read |
| cmdN | input | 1 | Command/data select, 0 = command, 1 = data |
| ecN | input | 1 | Active-low chain-enable request |
| dataIn | input | 16 | Data bus as seen from the pins |
| readData | input | 16 | Word from the core to present on reads |
| cfgChange | input | 1 | Pulse: active configuration set changed |
| localMatch | input | 1 | This device has at least one valid match |
| flagEnable | input | 1 | Match-flag enable bit from the control register |
| matchInN | input | 1 | Active-low match from higher-priority devices |
| dataOut | output | 16 | Data bus output value |
| dataOe | output | 1 | Data bus driver enable |
| cycleActive | output | 1 | A bus cycle is open |
| cycleKind | output | 2 | Latched {wrN, cmdN} of the current cycle |
| wrStrobe | output | 1 | One-cycle pulse at the end of a write cycle |
| wrData | output | 16 | Word captured at the end of the last write |
| segClk | output | 1 | One pulse per cycle for the segment counters |
| matchFlagN | output | 1 | Active-low chained match flag |
| selected | output | 1 | This device holds the highest-priority match |

## Verification
On every clock, the assertions check that the bus is driven only inside an open read cycle, that segment pulses last one cycle and coincide with the close of a cycle, that write strobes come only with a segment pulse, that a configuration change clears the flag, and that a selected device also shows a low flag. Only the bench's scenarios can show the things that need the stimulus history. These are the three-edge synchronizer latency, that late changes to the controls are ignored, the commit of ecN at the close of the cycle, and the full flag truth table under each combination of flagEnable, localMatch and matchInN.

// File: rtl/camBusPkg.sv
package camBusPkg;
  localparam int BUS_W = 16;

  // Strobes the control half sends to the datapath every clock
  typedef struct packed {
    logic fall;   // strobe went low this cycle
    logic rise;   // strobe went high this cycle
    logic wrN;    // latched write select
    logic cmdN;   // latched command select
    logic ecN;    // latched chain-enable request
  } busStrobe_t;
endpackage

// File: rtl/camSync.sv
module camSync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= asyncIn;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/camBusCtrl.sv
module camBusCtrl
  import camBusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enN,
  input  logic       wrN,
  input  logic       cmdN,
  input  logic       ecN,
  output busStrobe_t strb
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] syncVec;
  logic enPrev, enS, wrS, cmdS, ecS;
  logic wrLat, cmdLat, ecLat;
  logic fall, rise;

  camSync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({enN, wrN, cmdN, ecN}),
    .syncOut(syncVec)
  );

  assign {enS, wrS, cmdS, ecS} = syncVec;
  assign fall = enPrev & ~enS;
  assign rise = ~enPrev & enS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b1;
      wrLat  <= 1'b1;
      cmdLat <= 1'b1;
      ecLat  <= 1'b1;
    end else begin
      enPrev <= enS;
      if (fall) begin
        wrLat  <= wrS;
        cmdLat <= cmdS;
        ecLat  <= ecS;
      end
    end
  end

  always_comb begin
    strb.fall = fall;
    strb.rise = rise;
    strb.wrN  = wrLat;
    strb.cmdN = cmdLat;
    strb.ecN  = ecLat;
  end
endmodule

// File: rtl/camBusDatapath.sv
module camBusDatapath
  import camBusPkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  busStrobe_t    strb,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] readData,
  input  logic          cfgChange,
  input  logic          localMatch,
  input  logic          flagEnable,
  input  logic          matchInN,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic          cycleActive,
  output logic [1:0]    cycleKind,
  output logic          wrStrobe,
  output logic [DW-1:0] wrData,
  output logic          segClk,
  output logic          matchFlagN,
  output logic          selected
);
  logic active, chainOn;
  logic hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      chainOn  <= 1'b0;
      segClk   <= 1'b0;
      wrStrobe <= 1'b0;
      wrData   <= '0;
    end else begin
      segClk   <= strb.rise;
      wrStrobe <= strb.rise & ~strb.wrN;
      if (strb.rise && !strb.wrN) wrData <= dataIn;
      if (strb.fall) active <= 1'b1;
      else if (strb.rise) active <= 1'b0;
      if (cfgChange) chainOn <= 1'b0;
      else if (strb.rise) chainOn <= ~strb.ecN;
    end
  end

  assign hit         = flagEnable & localMatch;
  assign matchFlagN  = chainOn ? ~(hit | ~matchInN) : 1'b1;
  assign selected    = chainOn & hit & matchInN;
  assign cycleActive = active;
  assign cycleKind   = {strb.wrN, strb.cmdN};
  assign dataOe      = active & strb.wrN;
  assign dataOut     = readData;
endmodule

// File: rtl/camChainBus.sv
module camChainBus
  import camBusPkg::*;
#(
  parameter int DW = BUS_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enN,
  input  logic          wrN,
  input  logic          cmdN,
  input  logic          ecN,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] readData,
  input  logic          cfgChange,
  input  logic          localMatch,
  input  logic          flagEnable,
  input  logic          matchInN,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic          cycleActive,
  output logic [1:0]    cycleKind,
  output logic          wrStrobe,
  output logic [DW-1:0] wrData,
  output logic          segClk,
  output logic          matchFlagN,
  output logic          selected
);
  busStrobe_t strb;

  camBusCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enN(enN), .wrN(wrN), .cmdN(cmdN), .ecN(ecN),
    .strb(strb)
  );

  camBusDatapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .readData(readData),
    .cfgChange(cfgChange), .localMatch(localMatch), .flagEnable(flagEnable),
    .matchInN(matchInN), .dataOut(dataOut), .dataOe(dataOe),
    .cycleActive(cycleActive), .cycleKind(cycleKind), .wrStrobe(wrStrobe),
    .wrData(wrData), .segClk(segClk), .matchFlagN(matchFlagN), .selected(selected)
  );
endmodule

// File: rtl/camChainBusChk.sv
module camChainBusChk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgChange,
  input logic       dataOe,
  input logic       cycleActive,
  input logic [1:0] cycleKind,
  input logic       wrStrobe,
  input logic       segClk,
  input logic       matchFlagN,
  input logic       selected
);
  // R4: bus is driven only inside an open read cycle
  assert_bus_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (cycleActive && cycleKind[1]));

  // R5: segment pulse is one cycle long and ends an open cycle
  assert_seg_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    segClk |=> !segClk);
  assert_seg_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(segClk) |-> !cycleActive);

  // R6: write strobe comes only with the closing segment pulse
  assert_wr_with_seg_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> segClk);

  // R10: configuration change clears the chained flag
  assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgChange |=> (matchFlagN && !selected));

  // R11: a selected device also pulls the flag low
  assert_sel_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> !matchFlagN);
endmodule

bind camChainBus camChainBusChk u_chk (
  .clk(clk), .rstN(rstN), .cfgChange(cfgChange), .dataOe(dataOe),
  .cycleActive(cycleActive), .cycleKind(cycleKind), .wrStrobe(wrStrobe),
  .segClk(segClk), .matchFlagN(matchFlagN), .selected(selected)
);

// File: tb/camChainBus_bench.sv
module camChainBus_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enN = 1'b1, wrN = 1'b1, cmdN = 1'b1, ecN = 1'b1;
  logic [15:0] dataIn = '0, readData = '0;
  logic cfgChange = 1'b0, localMatch = 1'b0, flagEnable = 1'b0, matchInN = 1'b1;
  logic [15:0] dataOut, wrData;
  logic dataOe, cycleActive, wrStrobe, segClk, matchFlagN, selected;
  logic [1:0] cycleKind;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  camChainBus u_camChainBus (
    .clk(clk), .rstN(rstN), .enN(enN), .wrN(wrN), .cmdN(cmdN), .ecN(ecN),
    .dataIn(dataIn), .readData(readData), .cfgChange(cfgChange),
    .localMatch(localMatch), .flagEnable(flagEnable), .matchInN(matchInN),
    .dataOut(dataOut), .dataOe(dataOe), .cycleActive(cycleActive),
    .cycleKind(cycleKind), .wrStrobe(wrStrobe), .wrData(wrData),
    .segClk(segClk), .matchFlagN(matchFlagN), .selected(selected)
  );

  // Behavioural reference: input history queues model the sync delay
  bit hEn[$], hWr[$], hCmd[$], hEc[$];
  bit mActive, mWr, mCmd, mEc, mChain, mSeg, mWrStb;
  logic [15:0] mWrData;

  task automatic modelReset();
    hEn = '{1, 1, 1, 1}; hWr = '{1, 1, 1, 1};
    hCmd = '{1, 1, 1, 1}; hEc = '{1, 1, 1, 1};
    mActive = 0; mWr = 1; mCmd = 1; mEc = 1; mChain = 0;
    mSeg = 0; mWrStb = 0; mWrData = '0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit fall, rise;
      hEn.push_front(enN); hWr.push_front(wrN);
      hCmd.push_front(cmdN); hEc.push_front(ecN);
      void'(hEn.pop_back()); void'(hWr.pop_back());
      void'(hCmd.pop_back()); void'(hEc.pop_back());
      fall = hEn[3] && !hEn[2];
      rise = !hEn[3] && hEn[2];
      mSeg = rise;
      mWrStb = rise && !mWr;
      if (rise && !mWr) mWrData = dataIn;
      if (cfgChange) mChain = 0;
      else if (rise) mChain = !mEc;
      if (fall) begin
        mActive = 1; mWr = hWr[2]; mCmd = hCmd[2]; mEc = hEc[2];
      end else if (rise) mActive = 0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expFlag;
      expFlag = !mChain ? 1'b1 :
                (flagEnable ? !(localMatch || !matchInN) : matchInN);
      check("R3 cycleActive", cycleActive, mActive);
      check("R2 R3 cycleKind", cycleKind, {mWr, mCmd});
      check("R4 dataOe", dataOe, mActive && mWr);
      if (dataOe) check("R4 dataOut", dataOut, readData);
      check("R5 segClk", segClk, mSeg);
      check("R6 wrStrobe", wrStrobe, mWrStb);
      check("R6 wrData", wrData, mWrData);
      if (!mChain) check("R7 R10 matchFlagN", matchFlagN, 1'b1);
      else if (flagEnable) check("R8 matchFlagN", matchFlagN, expFlag);
      else check("R9 matchFlagN", matchFlagN, expFlag);
      check("R11 selected", selected, mChain && flagEnable && localMatch && matchInN);
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // One host bus cycle; lateFlip changes the controls while the strobe is low
  task automatic busCycle(bit w, bit c, bit e, logic [15:0] d, bit lateFlip);
    wrN = w; cmdN = c; ecN = e; dataIn = d; readData = ~d;
    waitCyc(2);
    enN = 0;
    waitCyc(5);
    if (lateFlip) begin wrN = !w; cmdN = !c; ecN = !e; end
    waitCyc(2);
    enN = 1;
    waitCyc(5);
    wrN = 1; cmdN = 1; ecN = 1;
    waitCyc(1);
  endtask

  task automatic flagSweep();
    for (int i = 0; i < 8; i++) begin
      {flagEnable, localMatch, matchInN} = i[2:0];
      waitCyc(1);
    end
  endtask

  initial begin
    waitCyc(3);
    // R1: reset state
    check("R1 matchFlagN", matchFlagN, 1'b1);
    check("R1 dataOe", dataOe, 1'b0);
    check("R1 segClk", segClk, 1'b0);
    check("R1 selected", selected, 1'b0);
    check("R1 cycleActive", cycleActive, 1'b0);
    rstN = 1;
    waitCyc(2);
    check("R1 wrStrobe", wrStrobe, 1'b0);

    busCycle(0, 0, 1, 16'h1234, 0);   // command write, chain off
    flagSweep();
    busCycle(0, 1, 0, 16'hbeef, 0);   // data write, chain on
    flagSweep();
    busCycle(1, 0, 0, 16'h0f0f, 0);   // command read
    flagSweep();
    busCycle(1, 1, 0, 16'h5a5a, 0);   // data read
    flagSweep();
    busCycle(1, 1, 0, 16'h7777, 1);   // R2: late flips ignored
    flagSweep();
    busCycle(0, 1, 1, 16'h2468, 1);   // R2: write, late ecN low ignored
    flagSweep();
    busCycle(0, 0, 0, 16'hc3c3, 0);
    {flagEnable, localMatch, matchInN} = 3'b111;
    waitCyc(2);
    check("R11 selected directed", selected, 1'b1);
    cfgChange = 1;                    // R10
    waitCyc(1);
    cfgChange = 0;
    check("R10 matchFlagN after cfgChange", matchFlagN, 1'b1);
    flagSweep();
    // R10: cfgChange right at commit time
    wrN = 1; cmdN = 1; ecN = 0;
    waitCyc(2); enN = 0; waitCyc(6); enN = 1;
    waitCyc(1); cfgChange = 1; waitCyc(4); cfgChange = 0;
    waitCyc(4); ecN = 1;
    flagSweep();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule